// File: doc/BRIEF.md
# Condition Run-Length Monitor

This block times how long a monitored condition stays asserted and turns each episode into one sample. A typical condition is "no instruction retired this cycle" or "a queue is full". Such conditions come and go rarely. Testing them against a threshold every cycle says little about them. What matters is how long each episode lasts. While the condition is high, a duration counter advances by one per clock. On the first clock where the condition is low again, the counter value is captured, presented with a one-cycle valid strobe, and the counter is cleared.

Each captured length is compared against a programmable threshold using one of three relations: at-least, below, or exactly-equal. Every length that passes the compare adds one to a qualifying-run counter. Every length, whether it passes or not, is added to a running duration total. Software can divide that total by the number of runs it observes to get the mean episode length. The run counter and the total both saturate and never wrap. The duration counter also saturates, so a run that is too long to measure is reported as the largest representable length.

Top module: `run_length_monitor`

## Requirements
- R1: While `cond_i` is sampled high, the duration advances by one per clock, starting from 1 on the first high cycle. A run of N high cycles (N below the saturation value) is reported as a sample of N.
- R2: The duration saturates at 2^DUR_W-1 (DUR_W defaults to 16). A run longer than that is reported as exactly 2^DUR_W-1.
- R3: On the first clock edge where `cond_i` is low after a run, `sample_o` takes the run length, and `sample_vld_o` is high for exactly the following cycle. Between captures, `sample_vld_o` is low and `sample_o` holds its last value.
- R4: The duration clears at the capture edge. A new run that starts after a single low cycle is measured from 1.
- R5: `mode_i` selects the compare: 0 passes when length >= `thresh_i`, 1 when length < `thresh_i`, 2 when length == `thresh_i`, and 3 never passes. The mode and threshold are taken at the capture edge.
- R6: A passing sample increments `pass_cnt_o` by 1, and a failing sample leaves it unchanged. The change is visible in the same cycle that `sample_vld_o` is high.
- R7: Every captured sample, whether passing or failing, is added to `dur_sum_o`. The new total is visible in the same cycle that `sample_vld_o` is high.
- R8: `pass_cnt_o` saturates at 2^CNT_W-1 and `dur_sum_o` saturates at 2^SUM_W-1. Neither wraps.
- R9: After reset, `sample_o`, `sample_vld_o`, `pass_cnt_o` and `dur_sum_o` are all zero.
- R10: While `cond_i` stays low with no run in progress, there is no capture and all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 1 | Qualified condition being timed |
| thresh_i | input | DUR_W | Threshold for the length compare |
| mode_i | input | 2 | Compare relation: 0 at-least, 1 below, 2 equal, 3 off |
| sample_o | output | DUR_W | Length of the most recent run |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |
| pass_cnt_o | output | CNT_W | Number of runs that passed the compare |
| dur_sum_o | output | SUM_W | Saturating total of all captured lengths |

## Verification
Two pairs of functions can land on the same edge.

The first pair is capture and the start of a new run. The bench drops the condition for a single cycle between two runs. It then checks that the second sample counts from 1 rather than continuing from the first length.

The second pair is saturation and capture. The bench holds the condition well past the counter limit, with the counter width reduced, so the capture happens while the duration is pinned at its maximum. It expects the maximum as the sample and in the added total. Separate runs drive the run counter and the total into their own limits, and the bench compares the results against a saturating model kept in the bench.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

    // Compare relation applied to a captured run length
    typedef enum logic [1:0] {
        CMP_AT_LEAST = 2'd0,
        CMP_BELOW    = 2'd1,
        CMP_EQUAL    = 2'd2,
        CMP_OFF      = 2'd3
    } cmp_mode_e;

endpackage

// File: rtl/rlm_run_timer.sv
module rlm_run_timer #(
    parameter int DUR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cond_i,
    output logic [DUR_W-1:0] len_o,
    output logic             end_o,
    output logic [DUR_W-1:0] smp_o,
    output logic             vld_o
);

    localparam logic [DUR_W-1:0] DUR_MAX = '1;
    localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

    typedef struct packed {
        logic [DUR_W-1:0] dur;
        logic [DUR_W-1:0] smp;
        logic             vld;
    } timer_st_t;

    timer_st_t st_d, st_q;
    logic      run_end;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        run_end  = !cond_i && (st_q.dur != '0);
        if (cond_i) begin
            if (st_q.dur != DUR_MAX) begin
                st_d.dur = st_q.dur + DUR_ONE;
            end
        end else if (run_end) begin
            st_d.smp = st_q.dur;
            st_d.vld = 1'b1;
            st_d.dur = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o = st_q.dur;
    assign end_o = run_end;
    assign smp_o = st_q.smp;
    assign vld_o = st_q.vld;

    // R1: the duration steps by one while the condition holds below the limit
    p_count_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i && st_q.dur != DUR_MAX) |=> (st_q.dur == $past(st_q.dur) + DUR_ONE));

    // R2: once at the limit, the duration stays there while the condition holds
    p_dur_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i && st_q.dur == DUR_MAX) |=> (st_q.dur == DUR_MAX));

    // R3: a run ending yields a strobe carrying the length reached
    p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cond_i && st_q.dur != '0) |=> (st_q.vld && st_q.smp == $past(st_q.dur)));

    // R3: the strobe never lasts two cycles
    p_vld_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.vld |=> !st_q.vld);

    // R4: the duration is zero right after a capture
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.vld |-> (st_q.dur == '0 || st_q.dur == DUR_ONE));

endmodule

// File: rtl/rlm_len_match.sv
module rlm_len_match
    import rlm_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic [DUR_W-1:0] len_i,
    input  logic [DUR_W-1:0] thresh_i,
    input  cmp_mode_e        mode_i,
    output logic             hit_o
);

    always_comb begin
        unique case (mode_i)
            CMP_AT_LEAST: hit_o = (len_i >= thresh_i);
            CMP_BELOW:    hit_o = (len_i <  thresh_i);
            CMP_EQUAL:    hit_o = (len_i == thresh_i);
            default:      hit_o = 1'b0;
        endcase
    end

    // R5: the disabled relation never reports a pass
    always_comb begin
        p_off_never_hits_r5: assert (!(mode_i == CMP_OFF && hit_o));
    end

endmodule

// File: rtl/rlm_sat_acc.sv
module rlm_sat_acc #(
    parameter int W    = 32,
    parameter int IN_W = 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic [IN_W-1:0] add_i,
    output logic [W-1:0]    sum_o
);

    localparam int WIDE_W = W + 1;

    typedef struct packed {
        logic [W-1:0] sum;
    } acc_st_t;

    acc_st_t           st_d, st_q;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        st_d = st_q;
        wide = {1'b0, st_q.sum} + WIDE_W'(add_i);
        if (en_i) begin
            st_d.sum = wide[W] ? '1 : wide[W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o = st_q.sum;

    // R8: the total never moves backwards, so it cannot wrap
    p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (st_q.sum >= $past(st_q.sum)));

    // R8: without an enable the total holds
    p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(st_q.sum));

endmodule

// File: rtl/run_length_monitor.sv
module run_length_monitor
    import rlm_pkg::*;
#(
    parameter int DUR_W = 16,
    parameter int CNT_W = 32,
    parameter int SUM_W = 48
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cond_i,
    input  logic [DUR_W-1:0] thresh_i,
    input  logic [1:0]       mode_i,
    output logic [DUR_W-1:0] sample_o,
    output logic             sample_vld_o,
    output logic [CNT_W-1:0] pass_cnt_o,
    output logic [SUM_W-1:0] dur_sum_o
);

    logic [DUR_W-1:0] run_len;
    logic             run_end;
    logic             len_hit;

    rlm_run_timer #(.DUR_W(DUR_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cond_i (cond_i),
        .len_o  (run_len),
        .end_o  (run_end),
        .smp_o  (sample_o),
        .vld_o  (sample_vld_o)
    );

    rlm_len_match #(.DUR_W(DUR_W)) u_match (
        .len_i    (run_len),
        .thresh_i (thresh_i),
        .mode_i   (cmp_mode_e'(mode_i)),
        .hit_o    (len_hit)
    );

    rlm_sat_acc #(.W(CNT_W), .IN_W(1)) u_pass_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (run_end && len_hit),
        .add_i  (1'b1),
        .sum_o  (pass_cnt_o)
    );

    rlm_sat_acc #(.W(SUM_W), .IN_W(DUR_W)) u_dur_sum (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (run_end),
        .add_i  (run_len),
        .sum_o  (dur_sum_o)
    );

    // R6: the run counter only moves on a sample strobe
    p_cnt_with_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pass_cnt_o) |-> sample_vld_o);

    // R6: the run counter moves by at most one per sample
    p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_vld_o |-> (pass_cnt_o - $past(pass_cnt_o) <= CNT_W'(1)));

    // R7: the total only moves on a sample strobe
    p_sum_with_vld_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(dur_sum_o) |-> sample_vld_o);

    // R10: no strobe without a run in progress one cycle earlier
    p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cond_i && run_len == '0) |=> !sample_vld_o);

endmodule

// File: tb/tb_run_length_monitor.sv
`timescale 1ns/1ps
module tb_run_length_monitor;

    localparam int DUR_W   = 8;
    localparam int CNT_W   = 4;
    localparam int SUM_W   = 10;
    localparam int DUR_MAX = (1 << DUR_W) - 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int SUM_MAX = (1 << SUM_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cond = 1'b0;
    logic [DUR_W-1:0] thresh = '0;
    logic [1:0]       mode = 2'd0;
    logic [DUR_W-1:0] sample;
    logic             vld;
    logic [CNT_W-1:0] pass_cnt;
    logic [SUM_W-1:0] dur_sum;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    int exp_sum = 0;
    int exp_smp = 0;

    always #5 clk = ~clk;

    run_length_monitor #(.DUR_W(DUR_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cond_i       (cond),
        .thresh_i     (thresh),
        .mode_i       (mode),
        .sample_o     (sample),
        .sample_vld_o (vld),
        .pass_cnt_o   (pass_cnt),
        .dur_sum_o    (dur_sum)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic bit model_pass(input int len, input int thr, input int md);
        case (md)
            0:       return len >= thr;
            1:       return len <  thr;
            2:       return len == thr;
            default: return 1'b0;
        endcase
    endfunction

    // Called at a negedge with cond low and no run in progress.
    task automatic do_run(input int len, input int gap, input int thr, input int md,
                          input string tag);
        int  elen;
        bit  p;
        thresh = DUR_W'(thr);
        mode   = 2'(md);
        cond   = 1'b1;
        repeat (len) @(negedge clk);
        cond = 1'b0;
        @(negedge clk);
        elen = (len > DUR_MAX) ? DUR_MAX : len;
        p    = model_pass(elen, thr, md);
        if (p) exp_cnt = (exp_cnt + 1 > CNT_MAX) ? CNT_MAX : exp_cnt + 1;
        exp_sum = (exp_sum + elen > SUM_MAX) ? SUM_MAX : exp_sum + elen;
        exp_smp = elen;
        check({tag, " R3 strobe"}, int'(vld), 1);
        check({tag, " R1 R2 sample length"}, int'(sample), elen);
        check({tag, " R5 R6 run count"}, int'(pass_cnt), exp_cnt);
        check({tag, " R7 R8 total"}, int'(dur_sum), exp_sum);
        if (gap > 1) begin
            @(negedge clk);
            check({tag, " R3 strobe drops"}, int'(vld), 0);
            check({tag, " R3 sample holds"}, int'(sample), exp_smp);
            repeat (gap - 2) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R9 sample", int'(sample), 0);
        check("R9 strobe", int'(vld), 0);
        check("R9 run count", int'(pass_cnt), 0);
        check("R9 total", int'(dur_sum), 0);
    endtask

    task automatic t_idle;
        cond = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R10 idle strobe", int'(vld), 0);
            check("R10 idle total", int'(dur_sum), exp_sum);
        end
    endtask

    task automatic t_modes;
        do_run(5, 3, 3, 0, "ge pass");
        do_run(2, 3, 3, 0, "ge fail");
        do_run(3, 3, 3, 0, "ge boundary");
        do_run(2, 3, 3, 1, "lt pass");
        do_run(3, 3, 3, 1, "lt boundary");
        do_run(4, 3, 4, 2, "eq pass");
        do_run(5, 3, 4, 2, "eq fail");
        do_run(4, 3, 4, 3, "off R5");
        do_run(1, 3, 0, 0, "min run R1");
    endtask

    task automatic t_back_to_back;
        do_run(3, 1, 0, 0, "b2b first R4");
        do_run(4, 3, 0, 0, "b2b second R4");
        do_run(1, 1, 0, 0, "b2b short R4");
        do_run(1, 3, 0, 0, "b2b short2 R4");
    endtask

    task automatic t_saturate_dur;
        do_run(300, 3, 200, 0, "long R2");
        do_run(DUR_MAX, 3, DUR_MAX, 2, "exact max R2");
    endtask

    task automatic t_saturate_counters;
        for (int i = 0; i < 18; i++) begin
            do_run(2, 2, 0, 0, "fill R8");
        end
        check("R8 run count pinned", int'(pass_cnt), CNT_MAX);
        for (int i = 0; i < 4; i++) begin
            do_run(300, 2, 0, 1, "big R8");
        end
        check("R8 total pinned", int'(dur_sum), SUM_MAX);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_modes();
        t_back_to_back();
        t_saturate_dur();
        t_idle();
        t_saturate_counters();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule